// File: doc/BRIEF.md
# Dual-Output Clock Post-Divider

This block sits after a fast oscillator and divides its clock by a power of two to make output A. The ratio is chosen by a 3-bit select and may be changed while the clock runs, which lets the output frequency be moved up or down for margin testing. A second output, B, is derived from A. One select bit sets whether B runs at the same rate as A or at half of it.

Both outputs keep an exact 50% duty cycle. Each output has its own stop request. A stop takes hold at that output's next falling edge. A release restarts the output with a complete high phase. A ratio change, or a change of B's select, is only picked up at the moment when A is low and its phase counter wraps. Because of this, no output phase is ever cut short.

All state is clocked by the fast input clock. Both outputs leave the block from flip-flops.

Top module: `vco_post_div`

## Requirements
- R1: Output A's period is 2, 4, 8, 16, 32 or 64 input cycles for select codes 0 to 5, in that order. Codes 6 and 7 give a period of 64.
- R2: At every ratio, output A stays high for exactly half its period and low for the other half.
- R3: When `half_rate_b` is 0 and neither output is stopped, output B equals output A on every cycle.
- R4: When `half_rate_b` is 1, output B's period is twice A's. B stays high for one full A period and low for one full A period.
- R5: A rising edge of B only ever happens in the same cycle as a rising edge of A. In half-rate mode, B rises on every other rising edge of A.
- R6: A new ratio or B select is applied only where A is low and its counter wraps. While a change is under way, every high or low run of A lasts either the old or the new half period, never anything else. No run of B is shorter than the smaller of the two.
- R7: A stop request drives an output low only at that output's next falling edge, so a high phase already in progress completes at full width. The stopped output stays low while the request is held. The other output keeps running.
- R8: After a stop is released, the output restarts at a rising edge of its own phase with a full-width high phase.
- R9: While `rst_n` is low, both outputs are low. On the first input clock edge after release, both outputs go high. The first high phase uses the ratio selected at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel_a | input | 3 | Divide ratio select for output A |
| half_rate_b | input | 1 | 1: B at half of A's rate; 0: B equals A |
| stop_a | input | 1 | Stop request for output A |
| stop_b | input | 1 | Stop request for output B |
| clk_a | output | 1 | Divided output A |
| clk_b | output | 1 | Output B, derived from A |

## Verification
The hardest case to reach is a ratio change that arrives partway through a phase. For a mid-phase apply to show up as a wrong-length run, the old and new half periods must differ, and the change must land at many different points of a phase. The stimulus walks through every ordered pair of the six ratios. It toggles B's select on alternate pairs, and a run-length monitor accepts only the old or new half period for each run of A. Separate stop tests raise a request in the middle of a high phase and release it during a low phase, and measure the stopped output's last and first pulses.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Half period, in input cycles, for a select code; codes past the
  // largest ratio saturate at it.
  function automatic int unsigned half_len(input int unsigned code,
                                           input int unsigned max_log);
    int unsigned c;
    c = (code > max_log) ? max_log : code;
    return 32'd1 << c;
  endfunction

endpackage

// File: rtl/pdiv_phase.sv
module pdiv_phase #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 5,
  parameter int CNT_W   = MAX_LOG + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             bhalf_req,
  output logic             ph_q,
  output logic             ph_d,
  output logic             bhalf_d,
  output logic             wrap,
  output logic             load,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] half_q
);
  import pdiv_pkg::*;

  logic             bhalf_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] half_d;

  always_comb begin
    wrap    = (cnt_q == half_q - CNT_W'(1));
    load    = wrap & ~ph_q;
    cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
    ph_d    = ph_q ^ wrap;
    half_d  = load ? CNT_W'(half_len(int'(sel), MAX_LOG)) : half_q;
    bhalf_d = load ? bhalf_req : bhalf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      half_q  <= CNT_W'(1);
      ph_q    <= 1'b0;
      bhalf_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      ph_q    <= ph_d;
      bhalf_q <= bhalf_d;
    end
  end

endmodule

// File: rtl/pdiv_bstage.sv
module pdiv_bstage (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_a_q,
  input  logic ph_a_d,
  input  logic bhalf_d,
  output logic ph_b_q,
  output logic ph_b_d
);
  logic tog_q, tog_d, rise_a;

  always_comb begin
    rise_a = ph_a_d & ~ph_a_q;
    tog_d  = bhalf_d ? (tog_q ^ rise_a) : 1'b0;
    ph_b_d = bhalf_d ? tog_d : ph_a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      ph_b_q <= 1'b0;
    end else begin
      tog_q  <= tog_d;
      ph_b_q <= ph_b_d;
    end
  end

endmodule

// File: rtl/pdiv_gate.sv
module pdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_q,
  input  logic ph_d,
  input  logic stop_req,
  output logic out_q
);
  logic en_q, en_d, fall, out_d;

  always_comb begin
    fall  = ph_q & ~ph_d;
    en_d  = fall ? ~stop_req : en_q;
    out_d = ph_d & en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/vco_post_div.sv
module vco_post_div #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 5
) (
  input  logic             clk_vco,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel_a,
  input  logic             half_rate_b,
  input  logic             stop_a,
  input  logic             stop_b,
  output logic             clk_a,
  output logic             clk_b
);
  localparam int CNT_W = MAX_LOG + 1;
  localparam int N_OUT = 2;

  logic             ph_a_q, ph_a_d, ph_b_q, ph_b_d, bhalf_d;
  logic             wrap_a, load_cfg;
  logic [CNT_W-1:0] cnt_q, half_q;

  logic [N_OUT-1:0] ph_q_v, ph_d_v, stop_v, out_v;

  pdiv_phase #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG), .CNT_W(CNT_W)) u_phase (
    .clk       (clk_vco),
    .rst_n     (rst_n),
    .sel       (ratio_sel_a),
    .bhalf_req (half_rate_b),
    .ph_q      (ph_a_q),
    .ph_d      (ph_a_d),
    .bhalf_d   (bhalf_d),
    .wrap      (wrap_a),
    .load      (load_cfg),
    .cnt_q     (cnt_q),
    .half_q    (half_q)
  );

  pdiv_bstage u_bstage (
    .clk     (clk_vco),
    .rst_n   (rst_n),
    .ph_a_q  (ph_a_q),
    .ph_a_d  (ph_a_d),
    .bhalf_d (bhalf_d),
    .ph_b_q  (ph_b_q),
    .ph_b_d  (ph_b_d)
  );

  assign ph_q_v = {ph_b_q, ph_a_q};
  assign ph_d_v = {ph_b_d, ph_a_d};
  assign stop_v = {stop_b, stop_a};

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    pdiv_gate u_gate (
      .clk      (clk_vco),
      .rst_n    (rst_n),
      .ph_q     (ph_q_v[g]),
      .ph_d     (ph_d_v[g]),
      .stop_req (stop_v[g]),
      .out_q    (out_v[g])
    );
  end

  assign clk_a = out_v[0];
  assign clk_b = out_v[1];

endmodule

// File: rtl/pdiv_chk.sv
module pdiv_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] half_q,
  input logic             wrap_a,
  input logic             load_cfg,
  input logic             ph_a_q,
  input logic             clk_a,
  input logic             clk_b
);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);

  // R2
  phase_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_a |=> (ph_a_q != $past(ph_a_q)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cfg |=> $stable(half_q));

  // R8
  a_rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_a) |-> $rose(ph_a_q));

  // R7
  a_fall_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_a) |-> $fell(ph_a_q));

  // R5
  b_rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_b) |-> $rose(ph_a_q));

endmodule

bind vco_post_div pdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk_vco),
  .rst_n    (rst_n),
  .cnt_q    (cnt_q),
  .half_q   (half_q),
  .wrap_a   (wrap_a),
  .load_cfg (load_cfg),
  .ph_a_q   (ph_a_q),
  .clk_a    (clk_a),
  .clk_b    (clk_b)
);

// File: tb/sim_vco_post_div.sv
`timescale 1ns/1ps
module sim_vco_post_div;
  logic       clk = 1'b0;
  logic       rst_n, hb, sa, sb;
  logic [2:0] sel;
  logic       out_a, out_b;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  vco_post_div u0 (
    .clk_vco(clk), .rst_n(rst_n), .ratio_sel_a(sel), .half_rate_b(hb),
    .stop_a(sa), .stop_b(sb), .clk_a(out_a), .clk_b(out_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Half period from the ratio table: ratio = 2^(code+1), saturating at 64.
  function automatic int half_of(input int code);
    int ratio;
    ratio = 2;
    for (int k = 0; k < code && k < 5; k++) ratio = ratio * 2;
    return ratio / 2;
  endfunction

  // Run-length monitor for on-the-fly changes.
  bit   mon_on = 0;
  int   ho = 1, hn = 1;
  logic pa, pb;
  int   la, lb;
  bit   sta, stb;
  always @(negedge clk) begin
    if (!mon_on) begin
      sta = 0; stb = 0; la = 0; lb = 0; pa = out_a; pb = out_b;
    end else begin
      if (out_a !== pa) begin
        if (sta) chk(la == ho || la == hn, "R6 A run", la, hn);
        sta = 1; la = 1;
      end else la++;
      if (out_b !== pb) begin
        if (stb) chk(lb >= ((ho < hn) ? ho : hn), "R6 B run", lb, (ho < hn) ? ho : hn);
        stb = 1; lb = 1;
      end else lb++;
      pa = out_a; pb = out_b;
    end
  end

  task automatic measure(input int code, input bit bs);
    int h, ra, rb, mism, badrise, ar, br;
    logic qa, qb;
    bit fa, fb;
    h = half_of(code);
    sel = 3'(code); hb = bs;
    repeat (200) @(negedge clk);
    qa = out_a; qb = out_b; fa = 0; fb = 0; ra = 0; rb = 0;
    mism = 0; badrise = 0; ar = 0; br = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (out_a !== qa) begin
        if (fa) chk(ra == h, qa ? "R1 A high run" : "R2 A low run", ra, h);
        fa = 1; ra = 1;
        if (out_a) ar++;
      end else ra++;
      if (out_b !== qb) begin
        if (fb) chk(rb == (bs ? 2*h : h), bs ? "R4 B run" : "R3 B run", rb, bs ? 2*h : h);
        fb = 1; rb = 1;
        if (out_b) begin
          br++;
          if (!(out_a && !qa)) badrise++;
        end
      end else rb++;
      if (!bs && out_a !== out_b) mism++;
      qa = out_a; qb = out_b;
    end
    if (!bs) chk(mism == 0, "R3 B equals A", mism, 0);
    chk(badrise == 0, "R5 B rise without A rise", badrise, 0);
    if (bs) chk(2*br - ar <= 1 && ar - 2*br <= 1, "R5 every other A rise", 2*br, ar);
  endtask

  // Stop/restart test on one output (which=0: A, 1: B).
  task automatic stop_test(input bit which, input int hi_len);
    logic p, other_p;
    int hi, bad, toggles;
    bit found;
    p = which ? out_b : out_a;
    found = 0;
    for (int i = 0; i < 300 && !found; i++) begin
      @(negedge clk);
      if ((which ? out_b : out_a) && !p) found = 1;
      p = which ? out_b : out_a;
    end
    hi = 1;
    @(negedge clk);
    if (which ? out_b : out_a) hi++;
    if (which) sb = 1; else sa = 1;
    for (int i = 0; i < 200 && (which ? out_b : out_a); i++) begin
      @(negedge clk);
      if (which ? out_b : out_a) hi++;
    end
    chk(hi == hi_len, "R7 high phase completes under stop", hi, hi_len);
    bad = 0; toggles = 0;
    other_p = which ? out_a : out_b;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (which ? out_b : out_a) bad++;
      if ((which ? out_a : out_b) !== other_p) toggles++;
      other_p = which ? out_a : out_b;
    end
    chk(bad == 0, "R7 stopped output stays low", bad, 0);
    chk(toggles >= 4, "R7 other output keeps running", toggles, 4);
    if (which) sb = 0; else sa = 0;
    found = 0;
    p = which ? out_b : out_a;
    for (int i = 0; i < 300 && !found; i++) begin
      @(negedge clk);
      if ((which ? out_b : out_a) && !p) found = 1;
      p = which ? out_b : out_a;
    end
    chk(found, "R8 output restarts", found, 1);
    hi = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!(which ? out_b : out_a)) break;
      hi++;
    end
    chk(hi == hi_len, "R8 first high phase full width", hi, hi_len);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 0; sel = 3'd3; hb = 0; sa = 0; sb = 0;
    repeat (5) @(negedge clk);
    chk(out_a == 0, "R9 A low in reset", out_a, 0);
    chk(out_b == 0, "R9 B low in reset", out_b, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_a == 1, "R9 A high after first edge", out_a, 1);
    chk(out_b == 1, "R9 B high after first edge", out_b, 1);
    hi = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!out_a) break;
      hi++;
    end
    chk(hi == half_of(3), "R9 first phase uses selected ratio", hi, half_of(3));

    for (int code = 0; code < 8; code++)
      for (int bs = 0; bs < 2; bs++)
        measure(code, bit'(bs));

    // On-the-fly changes over every ordered pair of ratios (R6).
    ho = half_of(7); hn = ho;
    mon_on = 1;
    for (int f = 0; f < 6; f++)
      for (int t = 0; t < 6; t++) begin
        hn = half_of(f); sel = 3'(f); hb = 1'((f + t) & 1);
        repeat (200) @(negedge clk);
        ho = hn;
        hn = half_of(t); sel = 3'(t); hb = 1'(f & 1);
        repeat (200) @(negedge clk);
        ho = hn;
      end
    mon_on = 0;

    sel = 3'd2; hb = 0;
    repeat (200) @(negedge clk);
    stop_test(1'b0, half_of(2));
    sel = 3'd1; hb = 1;
    repeat (200) @(negedge clk);
    stop_test(1'b1, 2 * half_of(1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule